// File: doc/BRIEF.md
# Buffered Divider Control for a Frequency-Synthesis Loop

This block connects a byte-wide register write port to the digital dividers of a clock-multiplying loop. It holds a 4-bit reference prescale ratio and a feedback multiplier ratio. Software stages both ratios in shadow storage and then moves them into the active dividers in one step, so the loop never sees a mix of old and new ratios. The active prescaler divides the reference clock domain into a single-cycle update strobe that paces the loop's correction steps.

The reference source is picked by priority. When the high-frequency secondary oscillator is fitted and present, it is the reference, whether or not the primary oscillator is also running. Otherwise the primary oscillator is the reference. A control byte holds a loop-enable bit and a separate discriminator-enable bit. The discriminator runs only when both bits are set.

Software writes the multiplier through the low divider byte. It then writes the prescale value through the high divider byte, and that write commits both values at once. The active ratios, the update strobe and the enables go out to the analog loop.

Top module: `pll_div_ctrl`

## Requirements
- R1: After reset the active prescale and multiplier are 0, the multiplier shadow is 0, both enables are clear and the update strobe is low.
- R2: A write to address 0 (low divider byte) changes only the multiplier shadow. The active prescale and multiplier outputs keep their values.
- R3: A write to address 1 (high divider byte) loads the active prescale and the active multiplier, both from the same clock edge. The active multiplier takes the shadow value; both outputs change in the cycle after the write.
- R4: The multiplier shadow takes data bits [MUL_W-1:0] (bits 5:0 by default) of an address-0 write. The prescale takes data bits [3:0] of an address-1 write. All other data bits are ignored.
- R5: While the loop is enabled with active prescale P, the update strobe is high for one cycle in every P+1 cycles. With P = 0 it is high on every cycle.
- R6: A commit restarts the prescale count from zero. With the loop enabled, the first strobe after a commit of prescale P appears P cycles after the first cycle that shows the new ratio.
- R7: With a prescale above zero, the strobe never stays high for two consecutive cycles.
- R8: While the loop enable is clear, the strobe stays low and the count is held at zero. When the loop is enabled again, counting starts from zero.
- R9: A write to address 2 sets the loop enable from data bit 0 and the discriminator enable from data bit 1. The discriminator-run output is high only when both are set.
- R10: With the secondary oscillator fitted (default), the reference-select output follows the secondary-present input (1 = secondary, 0 = primary). The reference-valid output is high when either oscillator is present.
- R11: A write to address 3 changes no output and no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 low divider, 1 high divider, 2 control, 3 unused) |
| wr_data | input | 8 | Write data byte |
| hf_osc_present | input | 1 | Secondary high-frequency oscillator is running |
| lf_osc_present | input | 1 | Primary oscillator is running |
| ref_sel_hf | output | 1 | 1 selects the secondary oscillator as reference, 0 the primary |
| ref_ok | output | 1 | A reference source is available |
| loop_on | output | 1 | Loop enable |
| pfd_run | output | 1 | Discriminator enable, gated by the loop enable |
| upd_tick | output | 1 | Update strobe from the prescaler |
| act_pre | output | 4 | Active prescale ratio field |
| act_mul | output | MUL_W | Active multiplier ratio field |

## Verification
The assertions assume one register write per cycle at most, with the address and data stable across the edge that samples the strobe. They also assume the reset input is low before the first clock edge. The bench drives every input on the falling edge and holds it through the next rising edge, so each write is sampled exactly once. It asserts reset from time zero. Random traffic covers all four addresses and full data bytes, including the ignored upper bits. The oscillator-present inputs are toggled freely, because the selection logic has no state that could be disturbed.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_MUL_LO = 2'd0,
    REG_PRE_HI = 2'd1,
    REG_CTRL   = 2'd2,
    REG_RSVD   = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_LOOP_BIT = 0;
  localparam int unsigned CTRL_PFD_BIT  = 1;

  typedef struct packed {
    logic loop_en;
    logic pfd_en;
  } ctrl_t;

endpackage

// File: rtl/pll_rst_sync.sv
module pll_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/pll_div_regs.sv
module pll_div_regs
  import pll_div_pkg::*;
#(
  parameter int unsigned PRE_W   = 4,
  parameter int unsigned MUL_W   = 6,
  parameter logic [PRE_W-1:0] RST_PRE = '0,
  parameter logic [MUL_W-1:0] RST_MUL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PRE_W-1:0]  act_pre_o,
  output logic [MUL_W-1:0]  act_mul_o,
  output logic              commit_o,
  output ctrl_t             ctrl_o
);

  logic [MUL_W-1:0] shadow_mul_q, shadow_mul_d;
  logic [PRE_W-1:0] act_pre_q, act_pre_d;
  logic [MUL_W-1:0] act_mul_q, act_mul_d;
  ctrl_t            ctrl_q, ctrl_d;
  logic             wr_lo, wr_hi, wr_ctrl;
  logic             unused_data;

  assign unused_data = ^wr_data;

  always_comb begin
    wr_lo   = wr_en && (wr_addr == REG_MUL_LO);
    wr_hi   = wr_en && (wr_addr == REG_PRE_HI);
    wr_ctrl = wr_en && (wr_addr == REG_CTRL);
  end

  always_comb begin
    shadow_mul_d = shadow_mul_q;
    act_pre_d    = act_pre_q;
    act_mul_d    = act_mul_q;
    ctrl_d       = ctrl_q;
    if (wr_lo) begin
      shadow_mul_d = wr_data[MUL_W-1:0];
    end
    if (wr_hi) begin
      act_pre_d = wr_data[PRE_W-1:0];
      act_mul_d = shadow_mul_q;
    end
    if (wr_ctrl) begin
      ctrl_d.loop_en = wr_data[CTRL_LOOP_BIT];
      ctrl_d.pfd_en  = wr_data[CTRL_PFD_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_mul_q <= RST_MUL;
      act_pre_q    <= RST_PRE;
      act_mul_q    <= RST_MUL;
      ctrl_q       <= '0;
    end else begin
      if (wr_lo)   shadow_mul_q <= shadow_mul_d;
      if (wr_hi)   act_pre_q    <= act_pre_d;
      if (wr_hi)   act_mul_q    <= act_mul_d;
      if (wr_ctrl) ctrl_q       <= ctrl_d;
    end
  end

  assign act_pre_o = act_pre_q;
  assign act_mul_o = act_mul_q;
  assign commit_o  = wr_hi;
  assign ctrl_o    = ctrl_q;

  // R2: a low-byte write alone leaves the active dividers untouched
  a_r2_lo_write_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_MUL_LO) |=> ($stable(act_pre_o) && $stable(act_mul_o)));

  // R3: a commit loads both fields on the same edge
  a_r3_commit_loads_both: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_PRE_HI) |=>
      (act_pre_o == $past(wr_data[PRE_W-1:0]) && act_mul_o == $past(shadow_mul_q)));

  // R11: reserved address leaves the control bits alone
  a_r11_rsvd_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_RSVD) |=> ($stable(ctrl_o) && $stable(act_pre_o)));

endmodule

// File: rtl/pll_prescaler.sv
module pll_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] ratio_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap = (cnt_q == ratio_i);
    if (restart_i || !en_i) cnt_d = '0;
    else if (wrap)          cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = en_i && wrap;

  // R5: the count never runs past the active ratio
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ratio_i);

  // R7: with a ratio above zero the strobe lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && ratio_i != '0 && !restart_i) |=> !tick_o);

  // R8: a disabled loop leaves the count at zero
  a_r8_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));

endmodule

// File: rtl/pll_ref_sel.sv
module pll_ref_sel #(
  parameter bit HF_FITTED = 1'b1
) (
  input  logic hf_present_i,
  input  logic lf_present_i,
  output logic sel_hf_o,
  output logic ok_o
);

  generate
    if (HF_FITTED) begin : g_hf
      assign sel_hf_o = hf_present_i;
      assign ok_o     = hf_present_i | lf_present_i;
    end else begin : g_lf_only
      logic unused_hf;
      assign unused_hf = hf_present_i;
      assign sel_hf_o  = 1'b0;
      assign ok_o      = lf_present_i;
    end
  endgenerate

endmodule

// File: rtl/pll_div_ctrl.sv
module pll_div_ctrl
  import pll_div_pkg::*;
#(
  parameter int unsigned PRE_W     = 4,
  parameter int unsigned MUL_W     = 6,
  parameter bit          HF_FITTED = 1'b1,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             hf_osc_present,
  input  logic             lf_osc_present,
  output logic             ref_sel_hf,
  output logic             ref_ok,
  output logic             loop_on,
  output logic             pfd_run,
  output logic             upd_tick,
  output logic [PRE_W-1:0] act_pre,
  output logic [MUL_W-1:0] act_mul
);

  logic  rst_n;
  logic  commit;
  ctrl_t ctrl;

  pll_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  pll_div_regs #(.PRE_W(PRE_W), .MUL_W(MUL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .act_pre_o (act_pre),
    .act_mul_o (act_mul),
    .commit_o  (commit),
    .ctrl_o    (ctrl)
  );

  pll_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (ctrl.loop_en),
    .restart_i (commit),
    .ratio_i   (act_pre),
    .tick_o    (upd_tick)
  );

  pll_ref_sel #(.HF_FITTED(HF_FITTED)) u_ref (
    .hf_present_i (hf_osc_present),
    .lf_present_i (lf_osc_present),
    .sel_hf_o     (ref_sel_hf),
    .ok_o         (ref_ok)
  );

  assign loop_on = ctrl.loop_en;
  assign pfd_run = ctrl.loop_en & ctrl.pfd_en;

  // R8: no strobe leaves the block while the loop is off
  a_r8_no_tick_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_on |-> !upd_tick);

  // R9: the discriminator never runs without the loop
  a_r9_pfd_needs_loop: assert property (@(posedge clk) disable iff (!rst_n)
    pfd_run |-> loop_on);

endmodule

// File: tb/pll_div_ctrl_tb.sv
`timescale 1ns/1ps
module pll_div_ctrl_tb;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       hf_p, lf_p;
  logic       ref_sel_hf, ref_ok, loop_on, pfd_run, upd_tick;
  logic [3:0] act_pre;
  logic [5:0] act_mul;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural model state
  int m_pre, m_mul, m_sh, m_cnt;
  bit m_en, m_pfd;

  always #2.5 clk = ~clk;

  pll_div_ctrl u_dut (
    .clk(clk), .arst_n(arst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hf_osc_present(hf_p), .lf_osc_present(lf_p), .ref_sel_hf(ref_sel_hf), .ref_ok(ref_ok),
    .loop_on(loop_on), .pfd_run(pfd_run), .upd_tick(upd_tick),
    .act_pre(act_pre), .act_mul(act_mul)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model, updated on each rising edge
  always @(posedge clk) begin
    if (!arst_n) begin
      m_pre = 0; m_mul = 0; m_sh = 0; m_cnt = 0; m_en = 0; m_pfd = 0;
    end else begin
      bit commit;
      int ncnt;
      commit = wr_en && wr_addr == 2'd1;
      if (commit || !m_en)   ncnt = 0;
      else if (m_cnt == m_pre) ncnt = 0;
      else                   ncnt = m_cnt + 1;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_sh = wr_data % 64;
          2'd1: begin m_pre = wr_data % 16; m_mul = m_sh; end
          2'd2: begin m_en = wr_data[0]; m_pfd = wr_data[1]; end
          default: ;
        endcase
      end
      m_cnt = ncnt;
    end
  end

  // compare every cycle away from the rising edge
  always @(negedge clk) begin
    if (arst_n && !done) begin
      bit et;
      et = m_en && (m_cnt == m_pre);
      chk(upd_tick == et, "R5", "upd_tick", upd_tick, et);
      chk(act_pre == m_pre[3:0], "R3", "act_pre", act_pre, m_pre);
      chk(act_mul == m_mul[5:0], "R3", "act_mul", act_mul, m_mul);
      chk(loop_on == m_en, "R9", "loop_on", loop_on, m_en);
      chk(pfd_run == (m_en && m_pfd), "R9", "pfd_run", pfd_run, m_en && m_pfd);
      chk(ref_sel_hf == hf_p, "R10", "ref_sel_hf", ref_sel_hf, hf_p);
      chk(ref_ok == (hf_p | lf_p), "R10", "ref_ok", ref_ok, hf_p | lf_p);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cycles_to_tick(output int n);
    n = 0;
    while (!upd_tick && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    arst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; hf_p = 1'b0; lf_p = 1'b1;
    repeat (4) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(act_pre == 0 && act_mul == 0, "R1", "active dividers", {act_pre, act_mul}, 0);
    chk(!upd_tick && !loop_on && !pfd_run, "R1", "tick/enables", {upd_tick, loop_on, pfd_run}, 0);

    // R10 source priority
    hf_p = 1'b1; lf_p = 1'b1; @(negedge clk);
    chk(ref_sel_hf == 1'b1, "R10", "both present picks secondary", ref_sel_hf, 1);
    hf_p = 1'b0; lf_p = 1'b0; @(negedge clk);
    chk(ref_ok == 1'b0 && ref_sel_hf == 1'b0, "R10", "none present", {ref_ok, ref_sel_hf}, 0);
    lf_p = 1'b1;

    // R2 shadow only
    wr(2'd0, 8'h2A);
    chk(act_mul == 0 && act_pre == 0, "R2", "active after low write", act_mul, 0);
    // R3 / R4 commit with ignored upper bits
    wr(2'd1, 8'hF3);
    chk(act_pre == 4'd3, "R4", "prescale from bits 3:0", act_pre, 3);
    chk(act_mul == 6'h2A, "R3", "multiplier from shadow", act_mul, 42);
    wr(2'd0, 8'hC5);
    chk(act_mul == 6'h2A, "R2", "active mul kept", act_mul, 42);
    wr(2'd1, 8'h03);
    chk(act_mul == 6'h05, "R4", "multiplier from bits 5:0", act_mul, 5);

    // R9 control
    wr(2'd2, 8'h02);
    chk(pfd_run == 1'b0, "R9", "pfd without loop", pfd_run, 0);
    wr(2'd2, 8'h03);
    chk(pfd_run == 1'b1 && loop_on == 1'b1, "R9", "pfd with loop", pfd_run, 1);

    // R5 interval with prescale 3
    cycles_to_tick(n);
    @(negedge clk);
    cycles_to_tick(n);
    chk(n == 3, "R5", "gap after tick (P=3)", n, 3);

    // R6 restart on commit
    wr(2'd1, 8'h06);
    cycles_to_tick(n);
    chk(n == 6, "R6", "first tick after commit", n, 6);

    // R5 prescale zero: every cycle
    wr(2'd1, 8'h00);
    chk(upd_tick == 1'b1, "R5", "P=0 tick now", upd_tick, 1);
    @(negedge clk);
    chk(upd_tick == 1'b1, "R5", "P=0 tick next", upd_tick, 1);

    // R7 no back-to-back with P=5
    wr(2'd1, 8'h05);
    begin
      bit prev = 1'b0;
      bit dbl = 1'b0;
      for (int i = 0; i < 30; i++) begin
        if (prev && upd_tick) dbl = 1'b1;
        prev = upd_tick;
        @(negedge clk);
      end
      chk(!dbl, "R7", "consecutive ticks", dbl, 0);
    end

    // R8 loop off
    wr(2'd2, 8'h00);
    begin
      bit any = 1'b0;
      for (int i = 0; i < 20; i++) begin
        if (upd_tick) any = 1'b1;
        @(negedge clk);
      end
      chk(!any, "R8", "tick while off", any, 0);
    end
    wr(2'd2, 8'h01);
    cycles_to_tick(n);
    chk(n == 5, "R8", "restart from zero on enable", n, 5);

    // R11 reserved address
    wr(2'd3, 8'hFF);
    chk(act_pre == 4'd5 && act_mul == 6'h05 && loop_on && !pfd_run, "R11", "reserved write",
        {act_pre, act_mul}, {4'd5, 6'h05});

    // random traffic, model compared every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_en   = ($urandom_range(0, 3) == 0);
      wr_addr = 2'($urandom_range(0, 3));
      wr_data = 8'($urandom_range(0, 255));
      hf_p    = 1'($urandom_range(0, 1));
      lf_p    = 1'($urandom_range(0, 1));
    end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule